// File: doc/BRIEF.md
# Atomic Memory Unit with Reservation-Based Conditional Store

This block owns a small word-addressed memory and serves several requesters. Each requester presents an operation code, a word address and a write value. The operations are:

- plain load and store;
- atomic exchange;
- test-and-set;
- fetch-and-increment;
- reserve-and-load (load-linked);
- conditional store (store-conditional).

An internal fixed-priority arbiter picks one requester per cycle. The chosen operation reads the word, decides the new value and writes it back within that single cycle. No other access can land on the same location between the read and the write.

Each requester owns one reservation register that holds a valid bit and an address. Reserve-and-load sets that register. Any write to the reserved word clears it, whoever makes the write. A conditional store succeeds only while the requester's own reservation still covers the addressed word. It clears that reservation in every case.

A typical use is a spin lock. A lock word of zero means free and nonzero means held. A requester keeps issuing exchange with a nonzero value until the old word returned is zero.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads 0 and no response is presented. A store (code 1) writes its data. A load (code 0) returns the addressed word one cycle after its grant.
- R2: Exchange (code 2) returns the old word and writes the requester's data in the same operation.
- R3: Test-and-set (code 3) returns the old word. It writes the requester's data only when the old word is zero. A nonzero word is left unchanged.
- R4: Fetch-and-increment (code 4) returns the old word and stores the old word plus one, modulo 2^DATA_W.
- R5: At most one request is granted per cycle, and the lowest requester index with a valid request wins. The response appears on that requester's rspValid bit in the cycle after the grant. A requester that loses keeps its request pending until it is granted.
- R6: Reserve-and-load (code 5) returns the word and records a reservation for that address. A later conditional store (code 6) from the same requester to that address, with no write to it in between, writes its data and returns rspOk = 1.
- R7: A conditional store fails, returning rspOk = 0 and leaving memory unchanged, when its requester holds no reservation or holds one for a different address.
- R8: Any write to a reserved address clears every reservation on that address. This covers a store, an exchange, a test-and-set that writes, a fetch-and-increment and a successful conditional store, from any requester.
- R9: A conditional store clears its own requester's reservation whether it succeeds or fails, so a second conditional store without a new reserve-and-load fails.
- R10: rspOk is 0 for every operation other than a conditional store. Code 7 behaves as a load and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request pending, one bit per requester; hold until the response arrives |
| reqOp | input | NUM_REQ x 3 | Operation code per requester |
| reqAddr | input | NUM_REQ x ADDR_W | Word address per requester |
| reqData | input | NUM_REQ x DATA_W | Write value per requester |
| rspValid | output | NUM_REQ | One-hot response strobe for the requester served last cycle |
| rspData | output | DATA_W | Old value of the word that was accessed |
| rspOk | output | 1 | Conditional store succeeded |

## Verification
Errors inside the block reach the ports quickly. A corrupted memory word shows up in rspData on the next load, exchange or increment of that address. A stale or wrongly cleared reservation shows up only at the next conditional store from that requester, as a flipped rspOk and, when checked later, a wrong stored word. An arbitration fault moves the rspValid bit one cycle after the contended grant. The bench therefore compares every cycle against a behavioural model. It places directed conditional stores right after reservation-breaking writes, so that a reservation fault becomes visible within a few cycles.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FAI   = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } amu_op_e;

  typedef struct packed {
    logic memWe;   // write the word this cycle
    logic incSel;  // write old+1 instead of request data
    logic setRes;  // record reservation for the granted requester
    logic clrOwn;  // drop the granted requester's reservation
    logic scOk;    // conditional store succeeded
  } amu_strobe_t;
endpackage

// File: rtl/amu_arbiter.sv
module amu_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] reqValid,
  output logic [NUM_REQ-1:0] grant,
  output logic [IDX_W-1:0]   gntIdx,
  output logic               gntAny
);
  always_comb begin
    grant  = '0;
    gntIdx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (reqValid[i]) begin
        grant  = '0;
        grant[i] = 1'b1;
        gntIdx = IDX_W'(i);
      end
    end
    gntAny = |reqValid;
  end
endmodule

// File: rtl/amu_ctrl.sv
module amu_ctrl
  import amu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              gntAny,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] oldWord,
  input  logic              resHit,
  output amu_strobe_t       stb
);
  always_comb begin
    stb = '0;
    if (gntAny) begin
      unique case (amu_op_e'(op))
        OP_STORE, OP_SWAP: stb.memWe = 1'b1;
        OP_TAS:            stb.memWe = (oldWord == '0);
        OP_FAI: begin
          stb.memWe  = 1'b1;
          stb.incSel = 1'b1;
        end
        OP_LL:             stb.setRes = 1'b1;
        OP_SC: begin
          stb.clrOwn = 1'b1;
          stb.memWe  = resHit;
          stb.scOk   = resHit;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/amu_datapath.sv
module amu_datapath
  import amu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] grant,
  input  logic [IDX_W-1:0]   gntIdx,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  amu_strobe_t        stb,
  output logic [DATA_W-1:0]  oldWord,
  output logic               resHit,
  output logic [NUM_REQ-1:0] rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic               rspOk
);
  logic [DATA_W-1:0] memArr [DEPTH];
  logic [NUM_REQ-1:0] resValid;
  logic [ADDR_W-1:0]  resAddr [NUM_REQ];
  logic [DATA_W-1:0]  newWord;

  assign oldWord = memArr[addr];
  assign resHit  = resValid[gntIdx] && (resAddr[gntIdx] == addr);
  assign newWord = stb.incSel ? oldWord + DATA_W'(1) : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) memArr[w] <= '0;
    end else if (stb.memWe) begin
      memArr[addr] <= newWord;
    end
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resValid[r] <= 1'b0;
        resAddr[r]  <= '0;
      end else begin
        if (stb.memWe && resValid[r] && resAddr[r] == addr) resValid[r] <= 1'b0;
        if (grant[r] && stb.clrOwn) resValid[r] <= 1'b0;
        if (grant[r] && stb.setRes) begin
          resValid[r] <= 1'b1;
          resAddr[r]  <= addr;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= '0;
      rspData  <= '0;
      rspOk    <= 1'b0;
    end else begin
      rspValid <= grant;
      rspData  <= oldWord;
      rspOk    <= stb.scOk;
    end
  end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_REQ-1:0]             reqValid,
  input  logic [NUM_REQ-1:0][OP_W-1:0]   reqOp,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ-1:0][DATA_W-1:0] reqData,
  output logic [NUM_REQ-1:0]             rspValid,
  output logic [DATA_W-1:0]              rspData,
  output logic                           rspOk
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] grant;
  logic [IDX_W-1:0]   gntIdx;
  logic               gntAny;
  logic [DATA_W-1:0]  oldWord;
  logic               resHit;
  amu_strobe_t        stb;

  amu_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .reqValid(reqValid), .grant(grant), .gntIdx(gntIdx), .gntAny(gntAny)
  );

  amu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .gntAny(gntAny), .op(reqOp[gntIdx]), .oldWord(oldWord),
    .resHit(resHit), .stb(stb)
  );

  amu_datapath #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .grant(grant), .gntIdx(gntIdx),
    .addr(reqAddr[gntIdx]), .wdata(reqData[gntIdx]), .stb(stb),
    .oldWord(oldWord), .resHit(resHit),
    .rspValid(rspValid), .rspData(rspData), .rspOk(rspOk)
  );
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] reqValid,
  input logic [NUM_REQ-1:0] rspValid,
  input logic               rspOk
);
  localparam logic [NUM_REQ-1:0] ONE = NUM_REQ'(1);

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rspValid)); // R5

  AST_RSP_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid != '0) |=> ((rspValid & $past(reqValid)) == rspValid) && (rspValid != '0)); // R5

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid != '0) |=> ((rspValid != '0) && (($past(reqValid) & (rspValid - ONE)) == '0))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid == '0) |=> (rspValid == '0)); // R5

  AST_OK_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rspOk |-> (rspValid != '0)); // R10
endmodule

bind atomic_mem_unit amu_checker #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
  .rspValid(rspValid), .rspOk(rspOk)
);

// File: tb/atomic_mem_unit_test.sv
module atomic_mem_unit_test;
  localparam int NR = 4;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]         reqValid = '0;
  logic [NR-1:0][2:0]    reqOp = '0;
  logic [NR-1:0][AW-1:0] reqAddr = '0;
  logic [NR-1:0][DW-1:0] reqData = '0;
  logic [NR-1:0]         rspValid;
  logic [DW-1:0]         rspData;
  logic                  rspOk;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  atomic_mem_unit #(.NUM_REQ(NR), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid),
    .rspData(rspData), .rspOk(rspOk)
  );

  // behavioural reference model
  logic [DW-1:0] mMem [1<<AW];
  bit            mResV [NR];
  int            mResA [NR];
  logic [NR-1:0] expV = '0;
  logic [DW-1:0] expD = '0;
  logic          expOk = 1'b0;
  string         expTag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mMem[k]) mMem[k] = '0;
      foreach (mResV[k]) mResV[k] = 0;
      expV = '0; expD = '0; expOk = 0; expTag = "R1";
    end else begin
      int g;
      g = -1;
      for (int k = NR - 1; k >= 0; k--) if (reqValid[k]) g = k;
      expV = '0; expOk = 0;
      if (g >= 0) begin
        int a;
        int op;
        logic [DW-1:0] old;
        bit wr;
        logic [DW-1:0] nv;
        a = int'(reqAddr[g]); op = int'(reqOp[g]);
        old = mMem[a]; wr = 0; nv = reqData[g];
        expV[g] = 1'b1; expD = old;
        case (op)
          1: begin wr = 1; expTag = "R1"; end
          2: begin wr = 1; expTag = "R2"; end
          3: begin wr = (old == 0); expTag = "R3"; end
          4: begin wr = 1; nv = old + 16'd1; expTag = "R4"; end
          5: expTag = "R6";
          6: begin
            wr = mResV[g] && mResA[g] == a;
            expOk = wr;
            expTag = wr ? "R6" : "R7";
            mResV[g] = 0;
          end
          7: expTag = "R10";
          default: expTag = "R1";
        endcase
        if ($countones(reqValid) > 1) expTag = "R5";
        if (wr) begin
          mMem[a] = nv;
          for (int k = 0; k < NR; k++) if (mResV[k] && mResA[k] == a) mResV[k] = 0;
        end
        if (op == 5) begin mResV[g] = 1; mResA[g] = a; end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: compare against model at the falling edge, retire served requests
  task automatic tick();
    @(negedge clk);
    check(rspValid == expV, expTag, "rspValid", rspValid, expV);
    if (expV != '0) begin
      check(rspData == expD, expTag, "rspData", rspData, expD);
      check(rspOk == expOk, expTag, "rspOk", rspOk, expOk);
    end
    reqValid &= ~rspValid;
  endtask

  task automatic doOp(input int r, input int op, input int a, input int d,
                      output logic [DW-1:0] rd, output logic ok);
    reqOp[r] = 3'(op); reqAddr[r] = AW'(a); reqData[r] = DW'(d);
    reqValid[r] = 1'b1;
    rd = 'x; ok = 1'bx;
    for (int n = 0; n < 10; n++) begin
      tick();
      if (rspValid[r]) begin rd = rspData; ok = rspOk; break; end
    end
  endtask

  initial begin : watchdog
    #500000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check(rspValid == '0, "R1", "idle after reset", rspValid, 0);

    doOp(1, 0, 3, 0, rd, ok);        check(rd == 0, "R1", "reset word", rd, 0);
    doOp(0, 1, 3, 16'h55, rd, ok);
    doOp(1, 0, 3, 0, rd, ok);        check(rd == 16'h55, "R1", "store/load", rd, 16'h55);
    doOp(2, 2, 3, 16'h99, rd, ok);   check(rd == 16'h55, "R2", "swap old", rd, 16'h55);
    check(ok == 0, "R10", "swap ok flag", ok, 0);
    doOp(1, 0, 3, 0, rd, ok);        check(rd == 16'h99, "R2", "swap wrote", rd, 16'h99);

    doOp(0, 3, 5, 1, rd, ok);        check(rd == 0, "R3", "tas free", rd, 0);
    doOp(1, 3, 5, 7, rd, ok);        check(rd == 1, "R3", "tas held", rd, 1);
    doOp(2, 0, 5, 0, rd, ok);        check(rd == 1, "R3", "tas no write", rd, 1);
    doOp(3, 2, 5, 1, rd, ok);        check(rd != 0, "R2", "spin sees held", rd, 1);

    doOp(0, 1, 6, 16'hFFFF, rd, ok);
    doOp(1, 4, 6, 0, rd, ok);        check(rd == 16'hFFFF, "R4", "fai old", rd, 16'hFFFF);
    doOp(1, 4, 6, 0, rd, ok);        check(rd == 0, "R4", "fai wrap", rd, 0);

    doOp(0, 5, 7, 0, rd, ok);
    doOp(0, 6, 7, 16'h1234, rd, ok); check(ok == 1, "R6", "sc success", ok, 1);
    doOp(1, 0, 7, 0, rd, ok);        check(rd == 16'h1234, "R6", "sc wrote", rd, 16'h1234);
    doOp(0, 6, 7, 16'h4321, rd, ok); check(ok == 0, "R9", "second sc", ok, 0);
    doOp(1, 0, 7, 0, rd, ok);        check(rd == 16'h1234, "R9", "no write", rd, 16'h1234);

    doOp(1, 6, 8, 16'h77, rd, ok);   check(ok == 0, "R7", "sc no reservation", ok, 0);
    doOp(1, 5, 8, 0, rd, ok);
    doOp(1, 6, 9, 16'h77, rd, ok);   check(ok == 0, "R7", "sc other addr", ok, 0);
    doOp(2, 0, 9, 0, rd, ok);        check(rd == 0, "R7", "no write", rd, 0);

    doOp(2, 5, 8, 0, rd, ok);
    doOp(3, 5, 8, 0, rd, ok);
    doOp(0, 4, 8, 0, rd, ok);
    doOp(2, 6, 8, 16'h11, rd, ok);   check(ok == 0, "R8", "fai broke reservation", ok, 0);
    doOp(3, 6, 8, 16'h22, rd, ok);   check(ok == 0, "R8", "all holders cleared", ok, 0);
    doOp(1, 5, 10, 0, rd, ok);
    doOp(2, 5, 10, 0, rd, ok);
    doOp(1, 6, 10, 16'hA, rd, ok);   check(ok == 1, "R6", "first sc", ok, 1);
    doOp(2, 6, 10, 16'hB, rd, ok);   check(ok == 0, "R8", "sc broke other", ok, 0);
    doOp(2, 5, 11, 0, rd, ok);
    doOp(0, 3, 11, 5, rd, ok);
    doOp(2, 6, 11, 16'hC, rd, ok);   check(ok == 0, "R8", "tas broke reservation", ok, 0);

    // contention: three requesters at once
    for (int r = 0; r < NR; r++) begin
      reqOp[r] = 3'd4; reqAddr[r] = AW'(12); reqData[r] = '0;
    end
    reqValid = 4'b1011;
    tick(); check(rspValid == 4'b0001, "R5", "first grant", rspValid, 1);
    tick(); check(rspValid == 4'b0010, "R5", "second grant", rspValid, 2);
    check(rspData == 1, "R5", "serialized", rspData, 1);
    tick(); check(rspValid == 4'b1000, "R5", "third grant", rspValid, 8);
    check(rspData == 2, "R5", "serialized", rspData, 2);

    doOp(0, 7, 12, 16'hDEAD, rd, ok); check(rd == 3 && ok == 0, "R10", "code 7", rd, 3);
    doOp(1, 0, 12, 0, rd, ok);        check(rd == 3, "R10", "code 7 no write", rd, 3);

    // mixed traffic, checked by the model every cycle
    for (int n = 0; n < 400; n++) begin
      for (int r = 0; r < NR; r++) begin
        if (!reqValid[r] && ($urandom % 2)) begin
          reqOp[r] = 3'($urandom); reqAddr[r] = AW'($urandom % 4);
          reqData[r] = DW'($urandom % 3); reqValid[r] = 1'b1;
        end
      end
      tick();
    end
    reqValid = '0;
    repeat (3) tick();

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule